// File: doc/BRIEF.md
# Periodic-Refresh Watchdog Reset Timer

This block watches for software that has stopped running its main loop. A slow tick strobe, one system-clock cycle wide and arriving twice per second, advances a small binary counter. If software lets the counter run past its top value, the block raises a reset request for the whole system. To stay alive, software writes a one to the refresh bit of a nibble-wide control register. That write returns the counter to zero. The low bits of the same register read back the live count, and the refresh bit always reads as zero.

A small controller sits beside the counter and has two named states. `ST_CLEAR` means the counter holds zero, which is true after reset, after a refresh and after an overflow. `ST_COUNT` means at least one tick has been counted since then. The controller has these transitions:
- `CLEAR_TO_COUNT`: a tick arrives with no refresh.
- `COUNT_TO_CLEAR_REFRESH`: a refresh write.
- `COUNT_TO_CLEAR_WRAP`: a tick at the counter's top value. This is the only event that fires the reset request.
- Every other cycle holds the state.

The counter keeps running while the processor is halted. A build-time parameter can remove the function. With the 3-bit default, the timeout falls 3.5 to 4 seconds after the last refresh, depending on where the refresh lands relative to the tick. Software must therefore refresh at least every 3 seconds.

Top module: `tick_watchdog`

## Requirements
- R1: During and immediately after reset the count reads 0 and `reset_req` is low.
- R2: Each cycle with `tick_en` high and no refresh write increments the count by one. The count is read on `bus_rdata[2:0]`, with bit 0 the least significant.
- R3: A tick that arrives while the count is 7 drives `reset_req` high in that same cycle, and the count reads 0 in the next cycle.
- R4: `reset_req` is high only in a cycle that carries a tick at count 7, so it is never high for two consecutive cycles.
- R5: A write to address `REG_ADDR` with `bus_wdata[3]`=1 makes the count read 0 in the next cycle.
- R6: A write with `bus_wdata[3]`=0 leaves the count unchanged, and so does a write to any other address. In both cases the counter is still free to be ticked.
- R7: `bus_rdata[3]` always reads 0, and reads from any address other than `REG_ADDR` return 0.
- R8: When a refresh write and a tick fall in the same cycle, the refresh wins: the count becomes 0 and `reset_req` stays low, even at count 7.
- R9: With `ENABLE`=0, `reset_req` never asserts and the count always reads 0.
- R10: With no refresh, the eighth tick after a refresh or reset asserts `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe at 2 Hz from the clock timer |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data; bit 3 is the refresh bit |
| bus_rdata | output | 4 | Read data: {0, count[2:0]} at `REG_ADDR`, otherwise 0 |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A refresh write and a tick can fall in the same clock cycle. The sharpest case is a tick at count 7, where the refresh must suppress the overflow pulse. The bench provokes this once in a directed case and then many more times under random stimulus. In the random runs, ticks and refresh writes are drawn independently every cycle, so they often coincide at every count value. Each cycle the bench predicts both the pulse and the next count from a reference model in which the refresh takes priority, and compares the model against the ports.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_COUNT = 1'b1
    } wdt_state_e;
endpackage

// File: rtl/wdt_regif.sv
`timescale 1ns/1ps
module wdt_regif #(
    parameter int ADDR_W   = 4,
    parameter int CNT_W    = 3,
    parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [CNT_W:0]    wdata,
    input  logic [CNT_W-1:0]  count,
    output logic              refresh,
    output logic [CNT_W:0]    rdata
);
    localparam int KICK_BIT = CNT_W;

    logic hit;
    logic unused_wbits;

    assign hit          = (addr == REG_ADDR);
    assign refresh      = hit && we && wdata[KICK_BIT];
    assign unused_wbits = ^wdata[CNT_W-1:0];

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[CNT_W-1:0] = count;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int CNT_W  = 3,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             carry
);
    localparam logic [CNT_W-1:0] TOP = '1;

    generate
        if (ENABLE) begin : g_live
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clr) begin
                    cnt_q <= '0;
                end else if (inc) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign count = cnt_q;
            assign carry = inc && (cnt_q == TOP);
        end else begin : g_off
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ clr ^ inc;
            assign count     = '0;
            assign carry     = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tick_watchdog.sv
`timescale 1ns/1ps
module tick_watchdog #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 3,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'hE,
    parameter bit ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    output logic              reset_req
);
    import wdt_pkg::*;

    localparam int DATA_W = CNT_W + 1;

    wdt_state_e       state_q, state_d;
    logic             refresh;
    logic             cnt_inc;
    logic             carry;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] rdata_w;

    wdt_regif #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .REG_ADDR(REG_ADDR)
    ) u_regif (
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata[DATA_W-1:0]),
        .count  (count),
        .refresh(refresh),
        .rdata  (rdata_w)
    );

    wdt_counter #(
        .CNT_W (CNT_W),
        .ENABLE(ENABLE)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (refresh),
        .inc  (cnt_inc),
        .count(count),
        .carry(carry)
    );

    assign cnt_inc   = ENABLE && tick_en && !refresh;
    assign bus_rdata = rdata_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (cnt_inc) state_d = ST_COUNT;
            ST_COUNT: if (refresh || carry) state_d = ST_CLEAR;
            default:  state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        reset_req = 1'b0;
        unique case (state_q)
            ST_CLEAR: reset_req = 1'b0;
            ST_COUNT: reset_req = carry;
            default:  reset_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
    parameter int CNT_W  = 3,
    parameter bit ENABLE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             refresh,
    input logic [CNT_W-1:0] count,
    input logic             reset_req,
    input logic [3:0]       bus_rdata
);
    localparam logic [CNT_W-1:0] TOP = '1;

    p_msb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[3] == 1'b0);

    generate
        if (ENABLE) begin : g_on
            p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_en && !refresh && count != TOP) |=> count == $past(count) + 1'b1);
            p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                reset_req |=> count == '0);
            p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_en && !refresh && count == TOP) |-> reset_req);
            p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
                reset_req |-> (tick_en && count == TOP));
            p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
                reset_req |=> !reset_req);
            p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                refresh |=> count == '0);
            p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!tick_en && !refresh) |=> $stable(count));
            p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
                refresh |-> !reset_req);
        end else begin : g_off
            p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !reset_req && count == '0);
        end
    endgenerate
endmodule

bind tick_watchdog wdt_checker #(
    .CNT_W (CNT_W),
    .ENABLE(ENABLE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .refresh  (refresh),
    .count    (count),
    .reset_req(reset_req),
    .bus_rdata(bus_rdata)
);

// File: tb/sim_tick_watchdog.sv
`timescale 1ns/1ps
module sim_tick_watchdog;
    localparam logic [3:0] RA = 4'hE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] bus_addr = RA;
    logic       bus_we = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] rdata0, rdata1;
    logic       req0, req1;

    int checks = 0;
    int errors = 0;
    int mcnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_watchdog #(.REG_ADDR(RA), .ENABLE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .reset_req(req0));

    tick_watchdog #(.REG_ADDR(RA), .ENABLE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .reset_req(req1));

    function automatic logic [3:0] exp_rd(logic [3:0] a, int c);
        return (a == RA) ? {1'b0, 3'(c)} : 4'h0;
    endfunction

    function automatic bit is_kick(logic we, logic [3:0] a, logic [3:0] d);
        return we && (a == RA) && d[3];
    endfunction

    function automatic bit exp_fire(logic t, bit kick, int c);
        return t && !kick && (c == 7);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic t, logic we, logic [3:0] a, logic [3:0] d);
        bit kick;
        @(negedge clk);
        tick_en = t; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        kick = is_kick(we, a, d);
        check({tag, " rdata"}, int'(rdata0), int'(exp_rd(a, mcnt)));
        check({tag, " reset_req"}, int'(req0), int'(exp_fire(t, kick, mcnt)));
        check("R9 disabled reset_req", int'(req1), 0);
        check("R9 disabled rdata", int'(rdata1), 0);
        if (kick) mcnt = 0;
        else if (t) mcnt = (mcnt + 1) % 8;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rdata", int'(rdata0), 0);
        check("R1 reset reset_req", int'(req0), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mcnt = 0;
        step("R1 after reset", 1'b0, 1'b0, RA, 4'h0);
        // R2 R10 R3: eight ticks, last one fires, then wrap to 0
        for (int k = 0; k < 8; k++) step("R10 R2 tick run", 1'b1, 1'b0, RA, 4'h0);
        step("R3 wrap to zero", 1'b0, 1'b0, RA, 4'h0);
        step("R4 no second pulse", 1'b0, 1'b0, RA, 4'h0);
        for (int k = 0; k < 5; k++) step("R2 count up", 1'b1, 1'b0, RA, 4'h0);
        step("R6 write zero bit", 1'b0, 1'b1, RA, 4'h7);
        step("R6 after zero write", 1'b0, 1'b1, 4'h3, 4'hF);
        step("R7 other addr read", 1'b0, 1'b0, 4'h3, 4'h0);
        step("R6 after other addr", 1'b0, 1'b0, RA, 4'h0);
        step("R5 refresh write", 1'b0, 1'b1, RA, 4'h8);
        step("R5 count cleared", 1'b0, 1'b0, RA, 4'h0);
        for (int k = 0; k < 7; k++) step("R2 to top", 1'b1, 1'b0, RA, 4'h0);
        step("R8 refresh with tick at 7", 1'b1, 1'b1, RA, 4'hF);
        step("R8 count after tie", 1'b0, 1'b0, RA, 4'h0);
        for (int n = 0; n < 4000; n++) begin
            logic t, we;
            logic [3:0] a, d;
            t  = ($urandom % 3) == 0;
            we = ($urandom % 8) == 0;
            a  = (($urandom % 4) == 0) ? 4'($urandom) : RA;
            d  = 4'($urandom);
            step("R2 R3 R4 R5 R6 R7 R8 random", t, we, a, d);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule